// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small 16-bit processor built around an accumulator. The accumulator value is always the left operand, and whatever the block computes can only go back into the accumulator. The right operand arrives already chosen: it may come from a general register, an immediate word or a memory word. Addressing and operand fetch happen before this stage.

Each cycle in which `op_valid` is high, the 4-bit function code picks one of nine operations. The result is available combinationally on `alu_result`, and `acc_wr` tells the register file in the same cycle whether to load it into the accumulator. The zero, negative and carry flags are held in a small register inside the block. They take their new values on the clock edge that ends the operation, so they are visible from the following cycle. The overflow condition belongs to other instructions and no code here affects it. Shift and byte-swap work on the right operand, not on the accumulator. Compare sets the flags and leaves the accumulator alone.

Top module: `acc_alu`

## Requirements
- R1: Code 1 (add) drives `alu_result` = (acc_a + opnd_b) mod 2^16 with `acc_wr` high, and C becomes the carry out of bit 15 (0xF000 + 0x0001 gives 0xF001 with C=0).
- R2: Code 2 (subtract) drives `alu_result` = (acc_a - opnd_b) mod 2^16 with `acc_wr` high, and C becomes 1 exactly when acc_a is unsigned-less-than opnd_b.
- R3: Code 3 (compare) keeps `acc_wr` low and updates Z, N and C exactly as code 2 would for the same operands.
- R4: Codes 4, 5 and 6 drive the bitwise AND, OR and XOR of acc_a and opnd_b with `acc_wr` high, and clear C.
- R5: Code 7 drives opnd_b shifted left by one with bit 0 filled by 0, with `acc_wr` high, and C takes the old bit 15 of opnd_b. acc_a has no influence on the result.
- R6: Code 8 drives opnd_b shifted right by one with bit 15 filled by 0, with `acc_wr` high, and C takes the old bit 0 of opnd_b. acc_a has no influence on the result.
- R7: Code 9 drives opnd_b with its two bytes exchanged, with `acc_wr` high, and clears C.
- R8: After an edge on which codes 1 to 9 were presented with `op_valid` high, Z is 1 exactly when that 16-bit result was zero and N equals bit 15 of that result. The flags then hold until the next such edge.
- R9: Codes 0 and 10 to 15 keep `acc_wr` low and leave Z, N and C unchanged, even when `op_valid` is high.
- R10: While `op_valid` is low, `acc_wr` is low and Z, N and C keep their values, whatever the function code.
- R11: During and right after reset, Z, N and C read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_func | input | 4 | Function code, 1 to 9 defined |
| acc_a | input | 16 | Accumulator value, left operand |
| opnd_b | input | 16 | Selected right operand |
| alu_result | output | 16 | Combinational result |
| acc_wr | output | 1 | Load alu_result into the accumulator this cycle |
| flag_z | output | 1 | Registered zero flag |
| flag_n | output | 1 | Registered negative flag |
| flag_c | output | 1 | Registered carry/borrow flag |

## Verification
The hardest cases to show from the ports are the ones where nothing should happen. A compare, an unused code or an idle cycle must leave the flags alone. The flags are the only place this shows, so the stimulus first drives each flag to a value that would change, for example C set by a borrow or Z set by a zero sum, and only then applies the operation that must not touch it. The same setup comes before every logical and swap operation, so that clearing C shows up as a change. A long run of random operands and codes, including the unused ones, follows the directed cases and is checked against a model of the requirements.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [3:0] {
      FN_NOP = 4'd0,
      FN_ADD = 4'd1,
      FN_SUB = 4'd2,
      FN_CMP = 4'd3,
      FN_AND = 4'd4,
      FN_OR  = 4'd5,
      FN_XOR = 4'd6,
      FN_SHL = 4'd7,
      FN_SHR = 4'd8,
      FN_SWP = 4'd9
   } alu_fn_e;

   typedef enum logic [1:0] {
      BW_AND = 2'd0,
      BW_OR  = 2'd1,
      BW_XOR = 2'd2
   } bw_sel_e;

   typedef enum logic [1:0] {
      SH_LEFT  = 2'd0,
      SH_RIGHT = 2'd1,
      SH_SWAP  = 2'd2
   } sh_sel_e;

   typedef struct packed {
      logic z;
      logic n;
      logic c;
   } alu_flags_t;

   localparam int unsigned FUNC_W = 4;

   function automatic logic fn_known(logic [FUNC_W-1:0] f);
      return (f >= 4'd1) && (f <= 4'd9);
   endfunction

   function automatic logic fn_writes(logic [FUNC_W-1:0] f);
      return fn_known(f) && (f != FN_CMP);
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int unsigned W      = 16,
   parameter bit          RIPPLE = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         carry_flag
);

   logic [W-1:0] b_eff;
   logic         co;

   assign b_eff = sub ? ~b : b;

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] cy;
         assign cy[0] = sub;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]   = a[i] ^ b_eff[i] ^ cy[i];
            assign cy[i+1]  = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
         end
         assign co = cy[W];
      end else begin : g_behav
         logic [W:0] tot;
         assign tot = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
         assign sum = tot[W-1:0];
         assign co  = tot[W];
      end
   endgenerate

   // subtraction reports borrow, which is the inverted adder carry
   assign carry_flag = sub ? ~co : co;

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
   import acc_alu_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  bw_sel_e      sel,
   output logic [W-1:0] y
);

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign y[i] = (sel == BW_AND) ? (a[i] & b[i]) :
                       (sel == BW_OR)  ? (a[i] | b[i]) :
                                         (a[i] ^ b[i]);
      end
   endgenerate

endmodule

// File: rtl/alu_shuffle.sv
module alu_shuffle
   import acc_alu_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] b,
   input  sh_sel_e      sel,
   output logic [W-1:0] y,
   output logic         cout
);

   localparam int unsigned HALF = W / 2;

   generate
      if ((W % 2) != 0 || W < 2) begin : g_bad_width
         $error("alu_shuffle: width must be even and at least 2");
      end
   endgenerate

   always_comb begin
      unique case (sel)
         SH_LEFT: begin
            y    = {b[W-2:0], 1'b0};
            cout = b[W-1];
         end
         SH_RIGHT: begin
            y    = {1'b0, b[W-1:1]};
            cout = b[0];
         end
         default: begin
            y    = {b[HALF-1:0], b[W-1:HALF]};
            cout = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import acc_alu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       upd,
   input  alu_flags_t nxt,
   output alu_flags_t cur
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur <= '0;
      else if (upd)
         cur <= nxt;
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned FN_W         = 4,
   parameter bit          ADDER_RIPPLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [FN_W-1:0]   op_func,
   input  logic [DATA_W-1:0] acc_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic [DATA_W-1:0] alu_result,
   output logic              acc_wr,
   output logic              flag_z,
   output logic              flag_n,
   output logic              flag_c
);

   localparam int unsigned MSB = DATA_W - 1;

   generate
      if (FN_W != FUNC_W) begin : g_bad_fn_w
         $error("acc_alu: function code width must match the package");
      end
      if (DATA_W < 2) begin : g_bad_data_w
         $error("acc_alu: data width too small");
      end
   endgenerate

   alu_fn_e            fn;
   logic [DATA_W-1:0]  as_sum;
   logic               as_cf;
   logic               as_sub;
   logic [DATA_W-1:0]  bw_y;
   bw_sel_e            bw_sel;
   logic [DATA_W-1:0]  sh_y;
   logic               sh_c;
   sh_sel_e            sh_sel;
   logic               carry_nxt;
   logic               upd;
   alu_flags_t         flags_nxt;
   alu_flags_t         flags_cur;

   assign fn     = alu_fn_e'(op_func);
   assign as_sub = (fn == FN_SUB) || (fn == FN_CMP);

   always_comb begin
      unique case (fn)
         FN_OR:   bw_sel = BW_OR;
         FN_XOR:  bw_sel = BW_XOR;
         default: bw_sel = BW_AND;
      endcase
      unique case (fn)
         FN_SHR:  sh_sel = SH_RIGHT;
         FN_SWP:  sh_sel = SH_SWAP;
         default: sh_sel = SH_LEFT;
      endcase
   end

   alu_addsub #(.W(DATA_W), .RIPPLE(ADDER_RIPPLE)) u_addsub (
      .a          (acc_a),
      .b          (opnd_b),
      .sub        (as_sub),
      .sum        (as_sum),
      .carry_flag (as_cf)
   );

   alu_bitwise #(.W(DATA_W)) u_bitwise (
      .a   (acc_a),
      .b   (opnd_b),
      .sel (bw_sel),
      .y   (bw_y)
   );

   alu_shuffle #(.W(DATA_W)) u_shuffle (
      .b    (opnd_b),
      .sel  (sh_sel),
      .y    (sh_y),
      .cout (sh_c)
   );

   // result steering; compare shows the difference but never writes it
   always_comb begin
      alu_result = '0;
      carry_nxt  = 1'b0;
      case (fn)
         FN_ADD, FN_SUB, FN_CMP: begin
            alu_result = as_sum;
            carry_nxt  = as_cf;
         end
         FN_AND, FN_OR, FN_XOR: begin
            alu_result = bw_y;
            carry_nxt  = 1'b0;
         end
         FN_SHL, FN_SHR, FN_SWP: begin
            alu_result = sh_y;
            carry_nxt  = sh_c;
         end
         default: begin
            alu_result = '0;
            carry_nxt  = 1'b0;
         end
      endcase
   end

   assign upd         = op_valid && fn_known(op_func);
   assign acc_wr      = op_valid && fn_writes(op_func);
   assign flags_nxt.z = ~|alu_result;
   assign flags_nxt.n = alu_result[MSB];
   assign flags_nxt.c = carry_nxt;

   alu_flag_reg u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (upd),
      .nxt   (flags_nxt),
      .cur   (flags_cur)
   );

   assign flag_z = flags_cur.z;
   assign flag_n = flags_cur.n;
   assign flag_c = flags_cur.c;

   AST_IDLE_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable({flag_z, flag_n, flag_c})); // R10
   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> !acc_wr); // R10
   AST_UNUSED_CODE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !fn_known(op_func)) |=> $stable({flag_z, flag_n, flag_c})); // R9
   AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_func == FN_CMP) |-> !acc_wr); // R3
   AST_ZERO_TRACKS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && fn_known(op_func)) |=> (flag_z == ($past(alu_result) == '0))); // R8
   AST_NEG_TRACKS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && fn_known(op_func)) |=> (flag_n == $past(alu_result[MSB]))); // R8
   AST_LOGIC_CLEARS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_func == FN_AND || op_func == FN_OR || op_func == FN_XOR))
      |=> !flag_c); // R4
   AST_SWAP_CLEARS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_func == FN_SWP) |=> !flag_c); // R7
   AST_SHL_CARRY_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_func == FN_SHL) |=> (flag_c == $past(opnd_b[MSB]))); // R5
   AST_SHR_CARRY_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_func == FN_SHR) |=> (flag_c == $past(opnd_b[0]))); // R6

endmodule

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;

   localparam int CLK_P = 10;

   typedef struct {
      logic [3:0]  fn;
      logic        vld;
      logic [15:0] eres;
      logic        ewe;
      logic [2:0]  eflg;
      logic        chk_res;
      string       req;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_func = 4'd0;
   logic [15:0] acc_a = 16'd0;
   logic [15:0] opnd_b = 16'd0;
   logic [15:0] alu_result;
   logic        acc_wr;
   logic        flag_z, flag_n, flag_c;

   int n_chk = 0;
   int n_fail = 0;
   item_t q[$];
   logic [2:0] mflg = 3'b000;   // model of {z,n,c}

   always #(CLK_P/2) clk = ~clk;

   acc_alu dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_valid   (op_valid),
      .op_func    (op_func),
      .acc_a      (acc_a),
      .opnd_b     (opnd_b),
      .alu_result (alu_result),
      .acc_wr     (acc_wr),
      .flag_z     (flag_z),
      .flag_n     (flag_n),
      .flag_c     (flag_c)
   );

   task automatic check(input logic ok, input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(logic vld, logic [3:0] f);
      if (!vld) return "R10";
      case (f)
         4'd1: return "R1";
         4'd2: return "R2";
         4'd3: return "R3";
         4'd4, 4'd5, 4'd6: return "R4";
         4'd7: return "R5";
         4'd8: return "R6";
         4'd9: return "R7";
         default: return "R9";
      endcase
   endfunction

   // driver: one operation per cycle, expected item pushed to the scoreboard
   task automatic drive(input logic vld, input logic [3:0] f,
                        input logic [15:0] a, input logic [15:0] b);
      item_t it;
      logic [16:0] wide;
      logic [15:0] r;
      logic        c;
      logic        known;
      @(negedge clk);
      op_valid = vld;
      op_func  = f;
      acc_a    = a;
      opnd_b   = b;
      r = 16'd0;
      c = 1'b0;
      known = (f >= 4'd1 && f <= 4'd9);
      case (f)
         4'd1: begin wide = {1'b0, a} + {1'b0, b}; r = wide[15:0]; c = wide[16]; end
         4'd2, 4'd3: begin r = a - b; c = (a < b); end
         4'd4: r = a & b;
         4'd5: r = a | b;
         4'd6: r = a ^ b;
         4'd7: begin r = {b[14:0], 1'b0}; c = b[15]; end
         4'd8: begin r = {1'b0, b[15:1]}; c = b[0]; end
         4'd9: r = {b[7:0], b[15:8]};
         default: r = 16'd0;
      endcase
      if (vld && known) mflg = {(r == 16'd0), r[15], c};
      it.fn      = f;
      it.vld     = vld;
      it.eres    = r;
      it.ewe     = vld && known && (f != 4'd3);
      it.eflg    = mflg;
      it.chk_res = vld && known && (f != 4'd3);
      it.req     = req_of(vld, f);
      q.push_back(it);
   endtask

   // monitor: after each rising edge, compare outputs with the oldest item
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            if (it.chk_res)
               check(alu_result == it.eres, it.req, "result", alu_result, it.eres);
            check(acc_wr == it.ewe, it.req, "acc_wr", {15'd0, acc_wr}, {15'd0, it.ewe});
            check({flag_z, flag_n, flag_c} == it.eflg,
                  (it.vld && it.fn >= 4'd1 && it.fn <= 4'd9 && it.req != "R3") ? "R8" : it.req,
                  "flags{z,n,c}", {13'd0, flag_z, flag_n, flag_c}, {13'd0, it.eflg});
         end
      end
   end

   // watchdog
   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11: reset state
      check({flag_z, flag_n, flag_c} == 3'b000, "R11", "flags in reset",
            {13'd0, flag_z, flag_n, flag_c}, 16'd0);
      check(acc_wr == 1'b0, "R11", "acc_wr in reset", {15'd0, acc_wr}, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check({flag_z, flag_n, flag_c} == 3'b000, "R11", "flags after reset",
            {13'd0, flag_z, flag_n, flag_c}, 16'd0);

      // R1 add
      drive(1, 4'd1, 16'hf000, 16'h0001);
      drive(1, 4'd1, 16'hffff, 16'h0001);   // zero with carry
      drive(1, 4'd1, 16'h7fff, 16'h0001);
      // R2 subtract
      drive(1, 4'd2, 16'h0005, 16'h0007);   // borrow, negative
      drive(1, 4'd2, 16'h1234, 16'h1234);   // zero, no borrow
      // R3 compare after flags set: no write, flags as subtract
      drive(1, 4'd1, 16'h0000, 16'h0000);   // Z=1
      drive(1, 4'd3, 16'h0003, 16'h0009);
      drive(1, 4'd3, 16'h0009, 16'h0009);
      // R4 logical ops with C set beforehand
      drive(1, 4'd2, 16'h0000, 16'h0001);   // C=1
      drive(1, 4'd4, 16'hf0f0, 16'h0ff0);
      drive(1, 4'd2, 16'h0000, 16'h0001);
      drive(1, 4'd5, 16'h8000, 16'h0001);
      drive(1, 4'd2, 16'h0000, 16'h0001);
      drive(1, 4'd6, 16'haaaa, 16'haaaa);
      // R5 / R6 shifts act on the operand, not on A
      drive(1, 4'd7, 16'h1111, 16'h8001);
      drive(1, 4'd7, 16'hffff, 16'h4000);
      drive(1, 4'd8, 16'hffff, 16'h0003);
      drive(1, 4'd8, 16'h0000, 16'h0001);
      // R7 swap with C set beforehand
      drive(1, 4'd2, 16'h0000, 16'h0001);
      drive(1, 4'd9, 16'h5555, 16'h12ab);
      // R9 unused codes with every flag in a changeable state
      drive(1, 4'd2, 16'h0000, 16'h0001);   // N=1 C=1
      drive(1, 4'd0, 16'h0000, 16'h0000);
      drive(1, 4'd10, 16'h0001, 16'h0001);
      drive(1, 4'd15, 16'hffff, 16'hffff);
      drive(1, 4'd1, 16'h0000, 16'h0000);   // Z=1
      drive(1, 4'd12, 16'h8000, 16'h8000);
      // R10 idle with a live code on the bus
      drive(0, 4'd1, 16'hffff, 16'h0001);
      drive(0, 4'd2, 16'h0000, 16'h0005);
      drive(0, 4'd9, 16'h1234, 16'h5678);
      // random mix, back to back
      for (int i = 0; i < 400; i++) begin
         drive(($urandom % 8) != 0, 4'($urandom % 16), 16'($urandom), 16'($urandom));
      end
      drive(0, 4'd0, 16'd0, 16'd0);
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule